// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Manager

This block sits between a main SDRAM controller and the CKE and command pins of a single-rank SDR SDRAM. It lets the host put the device into power-down and bring it back out. The host raises a level request and holds it. The block waits until the main controller reports that every bank is precharged, then drives CKE low and acknowledges. While CKE is low the command pins carry only a NOP.

A power-down ends in one of two ways. The host can drop its request. Otherwise an internal counter reaches the programmed refresh limit and the block wakes the device by itself, because the device does no refreshing while powered down. On a forced wake the block pulses a refresh-due flag so that the main controller can schedule a refresh.

Each wake raises CKE with a NOP on that same edge. The block then holds NOPs through a recovery window of programmable length. After the window it hands the command bus back and raises ready.

Top module: `cke_power_manager`

## Requirements
- R1: After reset, cke is 1, ready is 1, pdAck is 0 and refreshDue is 0.
- R2: While the block is active and no armed request is pending, the command outputs {csN,rasN,casN,weN} equal the main controller's inputs {mcCsN,mcRasN,mcCasN,mcWeN} in the same cycle. A deselect (csN=1) passes through in the same way.
- R3: When pdReq is 1, the request is armed and banksIdle is 1, cke is 0 and pdAck is 1 from the next cycle. pdAck is 1 exactly while cke is 0.
- R4: While banksIdle is 0, an armed request does not lower cke, and commands keep passing through so that banks can be precharged. cke falls in the cycle after banksIdle is seen at 1.
- R5: In every cycle with cke at 0, the command outputs hold the NOP code {csN,rasN,casN,weN} = 4'b0111.
- R6: When pdReq falls during power-down, cke is 1 in the next cycle and the command outputs show NOP in that first cycle.
- R7: The NOP code is held and ready stays 0 for RECOVER_CYCLES consecutive cycles, counted from the first cycle with cke at 1. In the following cycle ready is 1 and commands pass through again.
- R8: If pdReq stays high, cke is held at 0 for exactly REFRESH_LIMIT cycles and then returns to 1.
- R9: refreshDue is 1 for exactly one cycle, the first cke-high cycle of a forced wake. It stays 0 on a host-driven wake.
- R10: After a forced wake, ready returns to 1 while pdReq is still high, and no new power-down begins until pdReq has been seen at 0.
- R11: ready is 0 from the cycle in which an armed pdReq is present until the recovery window completes.
- R12: If pdReq is withdrawn before entry, cke never goes low and ready returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pdReq | input | 1 | Host power-down request (level) |
| banksIdle | input | 1 | Main controller reports all banks precharged |
| mcCsN | input | 1 | Main controller chip select, active low |
| mcRasN | input | 1 | Main controller row strobe, active low |
| mcCasN | input | 1 | Main controller column strobe, active low |
| mcWeN | input | 1 | Main controller write enable, active low |
| pdAck | output | 1 | Device is in power-down |
| ready | output | 1 | Command bus available to the main controller |
| refreshDue | output | 1 | One-cycle pulse on a forced wake |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |

## Verification
The entry property assumes that the main controller issues no bank activation while it holds pdReq high, apart from the precharges it needs to close banks. It also assumes that banksIdle is valid in the cycle it is sampled. The stimulus keeps to this: while a request is armed it drives only precharge or read patterns on the controller bus, and it raises banksIdle only after the held-off phase has been observed. Read patterns are driven during power-down and recovery on purpose, so that the forced NOP is seen to override a non-idle command.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } sdramCmd_t;

  localparam sdramCmd_t CMD_NOP = '{csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HOLD   = 2'd1,
    ST_DOWN   = 2'd2,
    ST_WAKE   = 2'd3
  } pmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic forceNop;
    logic ckeLow;
  } pmStrobe_t;

endpackage

// File: rtl/cke_pm_datapath.sv
module cke_pm_datapath
  import cke_pm_pkg::*;
#(
  parameter int REFRESH_LIMIT  = 1000,
  parameter int RECOVER_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  pmStrobe_t strobe,
  input  sdramCmd_t mcCmd,
  output sdramCmd_t pinCmd,
  output logic      pinCke,
  output logic      pdExpire,
  output logic      wakeDone
);

  localparam int CNT_MAX = (REFRESH_LIMIT > RECOVER_CYCLES) ? REFRESH_LIMIT : RECOVER_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] EXPIRE_AT = CNT_W'(REFRESH_LIMIT - 1);
  localparam logic [CNT_W-1:0] WAKE_AT   = CNT_W'(RECOVER_CYCLES - 1);

  logic [CNT_W-1:0] cycleCnt;

  // shared counter: power-down length, then recovery length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.cntClear) begin
      cycleCnt <= '0;
    end else if (strobe.cntRun && (cycleCnt != {CNT_W{1'b1}})) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  assign pdExpire = (cycleCnt == EXPIRE_AT);
  assign wakeDone = (cycleCnt == WAKE_AT);

  assign pinCmd = strobe.forceNop ? CMD_NOP : mcCmd;
  assign pinCke = ~strobe.ckeLow;

endmodule

// File: rtl/cke_pm_control.sv
module cke_pm_control
  import cke_pm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdReq,
  input  logic      banksIdle,
  input  logic      pdExpire,
  input  logic      wakeDone,
  output pmStrobe_t strobe,
  output logic      pdAck,
  output logic      ready,
  output logic      refreshDue
);

  pmState_t state, stateNext;
  logic     armed, armedNext;
  logic     forcedWake;
  logic     dueReg;

  always_comb begin
    stateNext  = state;
    forcedWake = 1'b0;
    unique case (state)
      ST_ACTIVE: begin
        if (pdReq && armed) begin
          stateNext = banksIdle ? ST_DOWN : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!pdReq) begin
          stateNext = ST_ACTIVE;
        end else if (banksIdle) begin
          stateNext = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (pdExpire) begin
          stateNext  = ST_WAKE;
          forcedWake = 1'b1;
        end else if (!pdReq) begin
          stateNext = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (wakeDone) begin
          stateNext = ST_ACTIVE;
        end
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  // a forced wake disarms the request until the host lets it go
  always_comb begin
    armedNext = armed;
    if (forcedWake && pdReq) begin
      armedNext = 1'b0;
    end else if (!pdReq) begin
      armedNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_ACTIVE;
      armed  <= 1'b1;
      dueReg <= 1'b0;
    end else begin
      state  <= stateNext;
      armed  <= armedNext;
      dueReg <= forcedWake;
    end
  end

  always_comb begin
    strobe.cntClear = (stateNext != state) &&
                      ((stateNext == ST_DOWN) || (stateNext == ST_WAKE));
    strobe.cntRun   = (state == ST_DOWN) || (state == ST_WAKE);
    strobe.forceNop = (state == ST_DOWN) || (state == ST_WAKE);
    strobe.ckeLow   = (state == ST_DOWN);
  end

  assign pdAck      = (state == ST_DOWN);
  assign ready      = (state == ST_ACTIVE) && !(pdReq && armed);
  assign refreshDue = dueReg;

endmodule

// File: rtl/cke_power_manager.sv
module cke_power_manager
  import cke_pm_pkg::*;
#(
  parameter int REFRESH_LIMIT  = 1000,
  parameter int RECOVER_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdReq,
  input  logic banksIdle,
  input  logic mcCsN,
  input  logic mcRasN,
  input  logic mcCasN,
  input  logic mcWeN,
  output logic pdAck,
  output logic ready,
  output logic refreshDue,
  output logic cke,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN
);

  pmStrobe_t strobe;
  sdramCmd_t mcCmd, pinCmd;
  logic      pdExpire, wakeDone;

  assign mcCmd = '{csN: mcCsN, rasN: mcRasN, casN: mcCasN, weN: mcWeN};

  cke_pm_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .pdReq      (pdReq),
    .banksIdle  (banksIdle),
    .pdExpire   (pdExpire),
    .wakeDone   (wakeDone),
    .strobe     (strobe),
    .pdAck      (pdAck),
    .ready      (ready),
    .refreshDue (refreshDue)
  );

  cke_pm_datapath #(
    .REFRESH_LIMIT  (REFRESH_LIMIT),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mcCmd    (mcCmd),
    .pinCmd   (pinCmd),
    .pinCke   (cke),
    .pdExpire (pdExpire),
    .wakeDone (wakeDone)
  );

  assign csN  = pinCmd.csN;
  assign rasN = pinCmd.rasN;
  assign casN = pinCmd.casN;
  assign weN  = pinCmd.weN;

endmodule

// File: rtl/cke_pm_checker.sv
module cke_pm_checker #(
  parameter int REFRESH_LIMIT  = 1000,
  parameter int RECOVER_CYCLES = 3
) (
  input logic clk,
  input logic rstN,
  input logic pdReq,
  input logic banksIdle,
  input logic pdAck,
  input logic ready,
  input logic refreshDue,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN
);

  localparam int RUN_MAX = (REFRESH_LIMIT > RECOVER_CYCLES) ? REFRESH_LIMIT : RECOVER_CYCLES;
  localparam int RUN_W   = $clog2(RUN_MAX + 2);

  logic             isNop, isIdleCmd;
  logic [RUN_W-1:0] lowRun, highRun;

  assign isNop     = !csN && rasN && casN && weN;
  assign isIdleCmd = csN || isNop;

  // cycles spent with cke low / high since the last change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= RUN_W'(RECOVER_CYCLES);
    end else if (!cke) begin
      highRun <= '0;
      if (lowRun != {RUN_W{1'b1}}) lowRun <= lowRun + 1'b1;
    end else begin
      lowRun <= '0;
      if (highRun < RUN_W'(RECOVER_CYCLES)) highRun <= highRun + 1'b1;
    end
  end

  a_r5_nop_while_low: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> isNop);

  a_r6_nop_on_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> isNop);

  a_r7_recovery_window: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !isIdleCmd) |-> (highRun >= RUN_W'(RECOVER_CYCLES)));

  a_r8_low_run_bounded: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (lowRun < RUN_W'(REFRESH_LIMIT)));

  a_r4_enter_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> $past(banksIdle));

  a_r3_ack_tracks_cke: assert property (@(posedge clk) disable iff (!rstN)
    pdAck == !cke);

  a_r9_due_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    refreshDue |-> ($rose(cke) && $past(pdReq)));

  a_r11_not_ready_when_low: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !ready);

endmodule

bind cke_power_manager cke_pm_checker #(
  .REFRESH_LIMIT  (REFRESH_LIMIT),
  .RECOVER_CYCLES (RECOVER_CYCLES)
) u_cke_pm_checker (
  .clk        (clk),
  .rstN       (rstN),
  .pdReq      (pdReq),
  .banksIdle  (banksIdle),
  .pdAck      (pdAck),
  .ready      (ready),
  .refreshDue (refreshDue),
  .cke        (cke),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN)
);

// File: tb/test_cke_power_manager.sv
module test_cke_power_manager;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20;
  localparam int REC        = 3;
  localparam logic [3:0] NOP   = 4'b0111;
  localparam logic [3:0] ACT   = 4'b0011;
  localparam logic [3:0] READ  = 4'b0101;
  localparam logic [3:0] PRE   = 4'b0010;
  localparam logic [3:0] DESEL = 4'b1010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 1'b0;
  logic banksIdle = 1'b1;
  logic [3:0] mc = NOP;
  logic pdAck, ready, refreshDue, cke, csN, rasN, casN, weN;
  logic [3:0] outCmd;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  assign outCmd = {csN, rasN, casN, weN};

  always #(CLK_PERIOD / 2) clk = ~clk;

  cke_power_manager #(.REFRESH_LIMIT(LIMIT), .RECOVER_CYCLES(REC)) i_cke_power_manager (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .banksIdle(banksIdle),
    .mcCsN(mc[3]), .mcRasN(mc[2]), .mcCasN(mc[1]), .mcWeN(mc[0]),
    .pdAck(pdAck), .ready(ready), .refreshDue(refreshDue), .cke(cke),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // let an ongoing wake run out with pdReq low
  task automatic settle();
    pdReq = 1'b0;
    repeat (REC + 3) tick();
  endtask

  task automatic t_reset();
    tick();
    check(cke == 1'b1, "R1", "cke", cke, 1);
    check(ready == 1'b1, "R1", "ready", ready, 1);
    check(pdAck == 1'b0, "R1", "pdAck", pdAck, 0);
    check(refreshDue == 1'b0, "R1", "refreshDue", refreshDue, 0);
  endtask

  task automatic t_passthrough();
    mc = ACT; #1;
    check(outCmd == ACT, "R2", "activate", outCmd, ACT);
    mc = DESEL; #1;
    check(outCmd == DESEL, "R2", "deselect", outCmd, DESEL);
    tick();
  endtask

  task automatic t_enter_exit();
    mc = READ; banksIdle = 1'b1; pdReq = 1'b1; #1;
    check(ready == 1'b0, "R11", "ready on request", ready, 0);
    tick();
    check(cke == 1'b0, "R3", "cke after entry", cke, 0);
    check(pdAck == 1'b1, "R3", "pdAck", pdAck, 1);
    check(outCmd == NOP, "R5", "cmd while low", outCmd, NOP);
    repeat (3) begin
      tick();
      check(cke == 1'b0 && outCmd == NOP, "R5", "held low with NOP", outCmd, NOP);
    end
    pdReq = 1'b0;
    tick();
    check(cke == 1'b1, "R6", "cke on wake", cke, 1);
    check(outCmd == NOP, "R6", "NOP on wake edge", outCmd, NOP);
    check(refreshDue == 1'b0, "R9", "no due on host wake", refreshDue, 0);
    check(ready == 1'b0, "R7", "ready in window", ready, 0);
    for (int k = 1; k < REC; k++) begin
      tick();
      check(outCmd == NOP && ready == 1'b0, "R7", "window NOP", outCmd, NOP);
    end
    tick();
    check(ready == 1'b1, "R7", "ready after window", ready, 1);
    check(outCmd == READ, "R7", "pass after window", outCmd, READ);
  endtask

  task automatic t_hold();
    banksIdle = 1'b0; mc = PRE; pdReq = 1'b1;
    repeat (4) begin
      tick();
      check(cke == 1'b1, "R4", "held off", cke, 1);
      check(outCmd == PRE, "R4", "precharge passes", outCmd, PRE);
      check(ready == 1'b0, "R11", "ready while held", ready, 0);
    end
    banksIdle = 1'b1;
    tick();
    check(cke == 1'b0, "R4", "entry after idle", cke, 0);
    settle();
    check(ready == 1'b1 && cke == 1'b1, "R4", "back to active", ready, 1);
  endtask

  task automatic t_withdraw();
    banksIdle = 1'b0; mc = PRE; pdReq = 1'b1;
    repeat (2) tick();
    pdReq = 1'b0;
    tick();
    check(ready == 1'b1, "R12", "ready after withdraw", ready, 1);
    banksIdle = 1'b1;
    repeat (3) begin
      tick();
      check(cke == 1'b1, "R12", "no entry", cke, 1);
    end
  endtask

  task automatic t_forced();
    int n;
    mc = READ; banksIdle = 1'b1; pdReq = 1'b1;
    tick();
    n = (cke == 1'b0) ? 1 : 0;
    for (int i = 0; i < LIMIT + 5; i++) begin
      tick();
      if (cke == 1'b0) n++;
      else break;
    end
    check(n == LIMIT, "R8", "cycles low", n, LIMIT);
    check(refreshDue == 1'b1, "R9", "due on forced wake", refreshDue, 1);
    check(outCmd == NOP, "R6", "NOP on forced wake", outCmd, NOP);
    tick();
    check(refreshDue == 1'b0, "R9", "due one cycle", refreshDue, 0);
    repeat (REC - 2) tick();
    tick();
    check(ready == 1'b1, "R10", "ready with pdReq high", ready, 1);
    repeat (5) begin
      tick();
      check(cke == 1'b1, "R10", "no re-entry", cke, 1);
    end
    pdReq = 1'b0;
    tick();
    pdReq = 1'b1;
    tick();
    check(cke == 1'b0, "R10", "re-entry after release", cke, 0);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset();
    t_passthrough();
    t_enter_exit();
    t_hold();
    t_withdraw();
    t_forced();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule